// File: doc/BRIEF.md
# Atomic Memory Operation Execution Unit

This unit computes the outcome of a single atomic read-modify-write. It is given the operand currently held in memory, the data supplied with the transaction, a category code, a sub-operation code, a size code and a byte-order bit. From these it forms the value that goes back to memory and the value that goes back to the requester. The integer and logic updates, swap and compare-and-swap are all computed in one combinational pass. The result is held in an output register for one cycle.

A memory-side controller feeds one operation per cycle through a valid/ready handshake. It takes the write-back value and the return value from the output side under the same handshake. When the return path stalls, the input side stops accepting. Fetching and storing the memory line is outside the block.

Top module: `amo_exec`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. An operation accepted at a clock edge appears on `out_new`/`out_ret` with `out_valid` high after that edge. `out_valid`, `out_new` and `out_ret` hold steady while `out_ready` is low. After reset `out_valid` is 0.
- R2: Category `in_kind` encodes 00 plain access, 01 store-type update, 10 load-type update, 11 swap family. A plain access leaves `out_new` equal to `in_old` and `out_ret` all zero.
- R3: The update sub-op codes for add and the bitwise operations are 000 add, 001 clear (old AND NOT operand), 010 exclusive-or, 011 set (old OR operand). Addition wraps modulo the operand size.
- R4: The comparison sub-op codes are 100 signed max, 101 signed min, 110 unsigned max, 111 unsigned min. The signed forms take the top bit of the selected size as the sign.
- R5: `in_big`=1 selects big-endian order (byte 0 most significant) for add and the four max/min sub-ops, and 0 selects little-endian. The bytes are reordered before and after the arithmetic. The bit has no effect on clear, exclusive-or and set.
- R6: Store-type and load-type operations produce the same `out_new`. Load-type returns the old operand in `out_ret`, and store-type returns all zero.
- R7: In category 11 with `in_subop[0]`=0 (swap), the low bytes of `in_data` are written and the old operand is returned.
- R8: In category 11 with `in_subop[0]`=1 (compare-and-swap), the compare value is `in_data` bytes [n-1:0] and the swap value is bytes [2n-1:n]. The swap value is written only if the old operand equals the compare value; otherwise `out_new` equals `in_old`. The old operand of n bytes is always returned.
- R9: The operand length is n = 2^`in_size` bytes. Codes are clamped to 3 (8 bytes) outside compare-and-swap and to 4 (16 bytes) for compare-and-swap. Bytes at n and above pass unchanged from `in_old` to `out_new` and are zero in `out_ret`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation accepted this cycle |
| in_kind | input | 2 | Category code |
| in_subop | input | 3 | Sub-operation code |
| in_size | input | 3 | log2 of operand length in bytes |
| in_big | input | 1 | Big-endian arithmetic |
| in_old | input | 128 | Current memory operand |
| in_data | input | 256 | Transaction data (compare and swap halves) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle |
| out_new | output | 128 | Value to write back |
| out_ret | output | 128 | Value returned to requester |

## Verification
A new operation can be accepted in the same cycle as the previous result is taken, and a stalled result can collide with a waiting operation. The sweep presents an operation every cycle with `out_ready` high, so every edge both drains one result and captures the next. Each result is judged against a bench model, one cycle after it was presented. A separate sequence holds `out_ready` low while a second operation waits. It checks that `in_ready` drops and that the first result stays frozen. After release, the waiting operation must take over on the very next edge.

// File: rtl/amo_exec.sv
module amo_exec #(
  parameter int HALF_BYTES  = 16,
  parameter int ARITH_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_kind,
  input  logic [2:0]                in_subop,
  input  logic [2:0]                in_size,
  input  logic                      in_big,
  input  logic [HALF_BYTES*8-1:0]   in_old,
  input  logic [HALF_BYTES*16-1:0]  in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [HALF_BYTES*8-1:0]   out_new,
  output logic [HALF_BYTES*8-1:0]   out_ret
);
  localparam int HW       = HALF_BYTES * 8;
  localparam int AW       = ARITH_BYTES * 8;
  localparam int NBW      = $clog2(HALF_BYTES) + 1;
  localparam int SHW      = $clog2(AW) + 1;
  localparam logic [2:0] CAS_MAX = 3'($clog2(HALF_BYTES));
  localparam logic [2:0] ARI_MAX = 3'($clog2(ARITH_BYTES));

  logic            is_cas;
  logic [2:0]      code;
  logic [NBW-1:0]  nb, anb;
  logic [HALF_BYTES-1:0] bmask;
  logic [HW-1:0]   wmask;

  assign is_cas = (in_kind == 2'b11) && in_subop[0];
  assign code   = is_cas ? ((in_size > CAS_MAX) ? CAS_MAX : in_size)
                         : ((in_size > ARI_MAX) ? ARI_MAX : in_size);
  assign nb     = NBW'(1) << code;
  assign anb    = (nb > NBW'(ARITH_BYTES)) ? NBW'(ARITH_BYTES) : nb;

  for (genvar i = 0; i < HALF_BYTES; i++) begin : g_mask
    assign bmask[i]        = NBW'(i) < nb;
    assign wmask[8*i +: 8] = {8{bmask[i]}};
  end

  function automatic logic [AW-1:0] flip(input logic [AW-1:0] x, input int n);
    logic [AW-1:0] r;
    r = '0;
    for (int i = 0; i < ARITH_BYTES; i++)
      if (i < n) r[8*i +: 8] = x[8*(n-1-i) +: 8];
    return r;
  endfunction

  // arithmetic / logic update path
  logic                 reorder;
  logic [AW-1:0]        a_raw, b_raw, a, b, r, r_m, r_out;
  logic [SHW-1:0]       sh;
  logic signed [AW-1:0] as, bs;

  assign reorder = in_big && (in_subop == 3'b000 || in_subop[2]);
  assign a_raw   = in_old[AW-1:0]  & wmask[AW-1:0];
  assign b_raw   = in_data[AW-1:0] & wmask[AW-1:0];
  assign a       = reorder ? flip(a_raw, int'(anb)) : a_raw;
  assign b       = reorder ? flip(b_raw, int'(anb)) : b_raw;
  assign sh      = SHW'(AW - 8 * int'(anb));
  assign as      = $signed(a << sh);
  assign bs      = $signed(b << sh);

  always_comb begin
    case (in_subop)
      3'b000:  r = a + b;
      3'b001:  r = a & ~b;
      3'b010:  r = a ^ b;
      3'b011:  r = a | b;
      3'b100:  r = (as > bs) ? a : b;
      3'b101:  r = (as < bs) ? a : b;
      3'b110:  r = (a > b) ? a : b;
      default: r = (a < b) ? a : b;
    endcase
  end

  assign r_m   = r & wmask[AW-1:0];
  assign r_out = reorder ? flip(r_m, int'(anb)) : r_m;

  // swap family path
  logic [2*HW-1:0] dshift;
  logic [HW-1:0]   cmpv, swpv, oldm, keep;
  logic            hit;

  assign dshift = in_data >> (8 * int'(nb));
  assign cmpv   = in_data[HW-1:0] & wmask;
  assign swpv   = dshift[HW-1:0] & wmask;
  assign oldm   = in_old & wmask;
  assign keep   = in_old & ~wmask;
  assign hit    = oldm == cmpv;

  logic [HW-1:0] nx_new, nx_ret;
  always_comb begin
    nx_new = in_old;
    nx_ret = '0;
    case (in_kind)
      2'b01: nx_new = keep | {{(HW-AW){1'b0}}, r_out};
      2'b10: begin
        nx_new = keep | {{(HW-AW){1'b0}}, r_out};
        nx_ret = oldm;
      end
      2'b11: begin
        nx_ret = oldm;
        if (!in_subop[0])  nx_new = keep | (in_data[HW-1:0] & wmask);
        else if (hit)      nx_new = keep | swpv;
      end
      default: ;
    endcase
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_new   <= '0;
      out_ret   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_new <= nx_new;
        out_ret <= nx_ret;
      end
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_new) && $stable(out_ret));
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  assert_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == 2'b00 |=> out_new == $past(in_old) && out_ret == '0);
  assert_store_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_kind == 2'b01 |=> out_ret == '0);
  assert_cas_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && is_cas && !hit |=> out_new == $past(in_old));
  assert_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ((out_new ^ $past(in_old)) & ~$past(wmask)) == '0
                             && (out_ret & ~$past(wmask)) == '0);
endmodule

// File: tb/sim_amo_exec.sv
module sim_amo_exec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [1:0] in_kind = '0;
  logic [2:0] in_subop = '0, in_size = '0;
  logic in_big = 1'b0;
  logic [127:0] in_old = '0;
  logic [255:0] in_data = '0;
  logic in_ready, out_valid;
  logic [127:0] out_new, out_ret;

  int tests = 0, fails = 0;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  amo_exec u0 (.*);

  always #10 clk = ~clk;

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [63:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 7; seed ^= seed << 17;
    return seed;
  endfunction

  function automatic logic [63:0] getv(input logic [127:0] x, input int n, input bit ord);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(x[8*(ord ? i : n-1-i) +: 8]);
    return v;
  endfunction

  function automatic logic signed [63:0] sx(input logic [63:0] v, input int n);
    logic [63:0] m = (n == 8) ? '1 : ((64'd1 << (8*n)) - 1);
    if (n < 8 && v[8*n-1]) return $signed(v | ~m);
    return $signed(v);
  endfunction

  task automatic model(input logic [1:0] k, input logic [2:0] s, input logic [2:0] z,
                       input bit big, input logic [127:0] o, input logic [255:0] d,
                       output logic [127:0] en, output logic [127:0] er, output int n);
    bit cas = (k == 2'b11) && s[0];
    int code = int'(z);
    bit ord, eq;
    logic [63:0] a, b, r, m;
    if (cas && code > 4) code = 4;
    if (!cas && code > 3) code = 3;
    n = 1 << code;
    en = o; er = '0;
    if (k == 2'b00) return;
    if (k == 2'b11) begin
      eq = 1'b1;
      for (int i = 0; i < n; i++) if (o[8*i +: 8] != d[8*i +: 8]) eq = 1'b0;
      for (int i = 0; i < n; i++) begin
        er[8*i +: 8] = o[8*i +: 8];
        if (!cas)    en[8*i +: 8] = d[8*i +: 8];
        else if (eq) en[8*i +: 8] = d[8*(n+i) +: 8];
      end
      return;
    end
    ord = big && (s == 3'd0 || s >= 3'd4);
    a = getv(o, n, ord);
    b = getv(d[127:0], n, ord);
    m = (n == 8) ? '1 : ((64'd1 << (8*n)) - 1);
    case (s)
      3'd0: r = a + b;
      3'd1: r = a & ~b;
      3'd2: r = a ^ b;
      3'd3: r = a | b;
      3'd4: r = (sx(a, n) >= sx(b, n)) ? a : b;
      3'd5: r = (sx(a, n) <= sx(b, n)) ? a : b;
      3'd6: r = (a >= b) ? a : b;
      default: r = (a <= b) ? a : b;
    endcase
    r &= m;
    for (int i = 0; i < n; i++) begin
      en[8*(ord ? n-1-i : i) +: 8] = r[8*i +: 8];
      if (k == 2'b10) er[8*i +: 8] = o[8*i +: 8];
    end
  endtask

  function automatic string tagof(input logic [1:0] k, input logic [2:0] s, input bit big);
    if (k == 2'b00) return "R2";
    if (k == 2'b11) return s[0] ? "R8" : "R7";
    if (big && (s == 3'd0 || s >= 3'd4)) return "R5";
    if (s >= 3'd4) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [127:0] p_new, p_ret, p_old;
  int p_n;
  string p_tag;
  logic [1:0] p_kind;
  bit pend = 1'b0;

  task automatic check_pending();
    logic [127:0] hm;
    if (!pend) return;
    chk(out_valid === 1'b1, "R1", "out_valid", 128'(out_valid), 128'd1);
    chk(out_new === p_new, p_tag, "new", out_new, p_new);
    chk(out_ret === p_ret, (p_kind == 2'b01 || p_kind == 2'b10) ? "R6" : p_tag,
        "ret", out_ret, p_ret);
    hm = '1;
    for (int i = 0; i < p_n; i++) hm[8*i +: 8] = 8'h00;
    chk(((out_new ^ p_old) & hm) == '0 && (out_ret & hm) == '0, "R9", "upper bytes",
        out_new, p_old);
    pend = 1'b0;
  endtask

  task automatic present(input logic [1:0] k, input logic [2:0] s, input logic [2:0] z,
                         input bit big, input logic [127:0] o, input logic [255:0] d);
    in_valid = 1'b1; in_kind = k; in_subop = s; in_size = z; in_big = big;
    in_old = o; in_data = d;
    model(k, s, z, big, o, d, p_new, p_ret, p_n);
    p_old = o; p_kind = k; p_tag = tagof(k, s, big); pend = 1'b1;
  endtask

  initial begin
    logic [127:0] o;
    logic [255:0] d;
    logic [127:0] hold_new;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid === 1'b0, "R1", "reset out_valid", 128'(out_valid), 128'd0);
    chk(in_ready === 1'b1, "R1", "reset in_ready", 128'(in_ready), 128'd1);

    // back-to-back sweep: each negedge checks the previous op and presents the next
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 8; s++)
        for (int z = 0; z < 8; z++)
          for (int bg = 0; bg < 2; bg++)
            for (int p = 0; p < 6; p++) begin
              o = {rnd(), rnd()};
              d = {rnd(), rnd(), rnd(), rnd()};
              case (p)
                1, 4: d[127:0] = o;
                2: begin o = {16{8'h7f}}; d = {32{8'h80}}; end
                3: begin o = '1; d = {32{8'h01}}; end
                default: ;
              endcase
              @(negedge clk);
              check_pending();
              present(2'(k), 3'(s), 3'(z), bit'(bg), o, d);
            end
    @(negedge clk);
    check_pending();
    in_valid = 1'b0;

    // stall: a held result meets a waiting operation (R1)
    @(negedge clk);
    out_ready = 1'b0;
    present(2'b10, 3'd0, 3'd2, 1'b1, 128'h11223344, 256'h01000000);
    @(negedge clk);
    hold_new = out_new;
    chk(in_ready === 1'b0, "R1", "in_ready while stalled", 128'(in_ready), 128'd0);
    chk(out_new === p_new, "R1", "stalled result", out_new, p_new);
    in_old = 128'hA5; in_data = 256'h5A; in_kind = 2'b11; in_subop = 3'd0; in_size = 3'd0;
    @(negedge clk);
    chk(out_valid === 1'b1 && out_new === hold_new, "R1", "held result", out_new, hold_new);
    check_pending();
    present(2'b11, 3'd0, 3'd0, 1'b0, 128'hA5, 256'h5A);
    out_ready = 1'b1;
    @(negedge clk);
    check_pending();
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "drain", 128'(out_valid), 128'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule